// File: doc/BRIEF.md
# Reset Sequencer with Start-Vector Fetch

This block sits between the reset sources of a small 8-bit microcontroller and its core. It merges two requests into one reset state: an active-low board reset pin and a reset request from the watchdog. The pin passes through a two-flop synchronizer. A level counter then qualifies it, so a low pulse shorter than the minimum width never disturbs a running program.

When every reset source has gone away, the block waits out an oscillator stabilization interval. It counts this interval as a prescaler of `PRESCALE` cycles repeated `STAB_STEPS` times. It then runs a fixed seven-cycle start-up fetch. The fetch reads the low byte of the start vector at FFFEh and then the high byte at FFFFh over an 8-bit data bus. The block assembles the 16-bit program counter from the two bytes and raises the run enable in the next cycle.

While reset is held, four initialization strobes tell the control logic to clear the G flag, disable the watchdog, stop the peripheral clock and disable the power-fail detector. The block has no write strobe at all, so RAM contents are left as they are. A new reset at any point, including during the wait or the fetch, sends the sequence back to its start.

Top module: `boot_sequencer`

## Requirements
- R1: A watchdog request (`wdt_rst_req` high at a clock edge) puts the block in reset: `core_rst` is high and `run_en` low from the following cycle.
- R2: The pin is sampled through two flops and counted. It is taken as a reset only after `MIN_LOW` (default 8) consecutive low samples, and `core_rst` rises 11 edges after the first low sample. A low pulse of 7 samples or fewer leaves `core_rst` low and `run_en` high.
- R3: `init_ctl` is 4'b1111 while `core_rst` is high and 4'b0000 otherwise. Bit 0 clears the G flag, bit 1 disables the watchdog, bit 2 stops the peripheral clock and bit 3 disables the power-fail detector.
- R4: After all sources are gone, the block waits exactly `PRESCALE*STAB_STEPS` cycles (default 1024*256) before the fetch starts.
- R5: The fetch lasts 7 cycles. `bus_rd` is high only in fetch cycles 6 and 7, with `bus_addr` FFFFh-1 (FFFEh) first and FFFFh second. `bus_addr` is 0 otherwise, and exactly two reads occur per completed sequence.
- R6: `pc_value` becomes {byte read at FFFFh, byte read at FFFEh}. `pc_load` pulses high for exactly one cycle, the first cycle of `run_en`.
- R7: `run_en` stays low from reset until the PC is loaded and rises on the cycle after the high-byte read. It rises `1+PRESCALE*STAB_STEPS+7` edges after a watchdog request or `rst` drops, and `4+PRESCALE*STAB_STEPS+7` edges after the pin returns high.
- R8: A reset taken during the stabilization wait or the fetch aborts the sequence. No further vector read occurs, and the full wait and fetch are repeated after release.
- R9: No bus read occurs while `run_en` is high.
- R10: Synchronous `rst` forces `core_rst` high, `run_en` low, `bus_rd` low and `pc_load` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst | input | 1 | Synchronous active-high power-on reset |
| ext_rst_n | input | 1 | Asynchronous active-low board reset pin level |
| wdt_rst_req | input | 1 | Watchdog reset request, synchronous to clk |
| bus_din | input | 8 | Read data from program memory |
| core_rst | output | 1 | Core held in reset while high |
| init_ctl | output | 4 | Initialization strobes (see R3) |
| bus_addr | output | 16 | Address presented during vector fetch |
| bus_rd | output | 1 | Read strobe during vector fetch |
| pc_value | output | 16 | Assembled start address |
| pc_load | output | 1 | One-cycle program counter load pulse |
| run_en | output | 1 | Core allowed to execute |

## Verification
The bench builds the block with `PRESCALE=4` and `STAB_STEPS=3`, so the stabilization wait is 12 cycles instead of 262144. This makes exact start-up latency checks after pin, watchdog and power-on release cheap. It also makes room to abort the sequence at a chosen cycle of the wait and between the two vector reads. `MIN_LOW` stays at 8, so the 7-sample and 8-sample pin pulses are tested at their real boundary.

// File: rtl/bootseq_pkg.sv
package bootseq_pkg;

    typedef enum logic [1:0] {
        SEQ_HOLD  = 2'd0,
        SEQ_STAB  = 2'd1,
        SEQ_FETCH = 2'd2,
        SEQ_RUN   = 2'd3
    } seq_state_e;

    typedef struct packed {
        logic pfd_off;
        logic pclk_off;
        logic wdt_dis;
        logic gflag_clr;
    } init_ctl_t;

    localparam int unsigned FETCH_CYCLES = 7;
    localparam int unsigned STEP_W       = 3;
    localparam logic [STEP_W-1:0] RD_LO_STEP = 3'd5;
    localparam logic [STEP_W-1:0] RD_HI_STEP = 3'd6;
    localparam logic [15:0] VEC_LO_ADDR = 16'hFFFE;
    localparam logic [15:0] VEC_HI_ADDR = 16'hFFFF;

    function automatic logic [15:0] fetch_addr(input logic [STEP_W-1:0] step);
        case (step)
            RD_LO_STEP: fetch_addr = VEC_LO_ADDR;
            RD_HI_STEP: fetch_addr = VEC_HI_ADDR;
            default:    fetch_addr = 16'h0000;
        endcase
    endfunction

    function automatic init_ctl_t init_all(input logic on);
        init_ctl_t v;
        v.pfd_off   = on;
        v.pclk_off  = on;
        v.wdt_dis   = on;
        v.gflag_clr = on;
        return v;
    endfunction

endpackage

// File: rtl/pin_qualifier.sv
module pin_qualifier #(
    parameter int unsigned MIN_LOW = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic pin_n,
    output logic ext_active
);
    localparam int unsigned CW = $clog2(MIN_LOW + 1);
    localparam logic [CW-1:0] CNT_MAX = CW'(MIN_LOW);

    logic          sync1, sync2;
    logic [CW-1:0] low_cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            sync1 <= 1'b1;
            sync2 <= 1'b1;
        end else begin
            sync1 <= pin_n;
            sync2 <= sync1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || sync2) begin
            low_cnt <= '0;
        end else if (low_cnt != CNT_MAX) begin
            low_cnt <= low_cnt + 1'b1;
        end
    end

    assign ext_active = (low_cnt == CNT_MAX);

    // R2: qualification only ever follows a synchronized low sample
    p_rise_needs_low_r2: assert property (@(posedge clk) disable iff (rst)
        $rose(ext_active) |-> $past(!sync2));

    // R2: a high sample always drops the qualified level
    p_high_clears_r2: assert property (@(posedge clk) disable iff (rst)
        sync2 |=> !ext_active);

endmodule

// File: rtl/stab_timer.sv
module stab_timer #(
    parameter int unsigned PRESCALE   = 1024,
    parameter int unsigned STAB_STEPS = 256
) (
    input  logic clk,
    input  logic rst,
    input  logic enable,
    output logic done
);
    localparam int unsigned PW = (PRESCALE   > 1) ? $clog2(PRESCALE)   : 1;
    localparam int unsigned SW = (STAB_STEPS > 1) ? $clog2(STAB_STEPS) : 1;
    localparam logic [PW-1:0] PRE_LAST  = PW'(PRESCALE - 1);
    localparam logic [SW-1:0] STEP_LAST = SW'(STAB_STEPS - 1);

    logic [PW-1:0] pre_cnt;
    logic [SW-1:0] step_cnt;
    logic          pre_wrap;

    assign pre_wrap = (pre_cnt == PRE_LAST);

    always_ff @(posedge clk) begin
        if (rst || !enable) begin
            pre_cnt  <= '0;
            step_cnt <= '0;
        end else if (pre_wrap) begin
            pre_cnt  <= '0;
            step_cnt <= step_cnt + 1'b1;
        end else begin
            pre_cnt  <= pre_cnt + 1'b1;
        end
    end

    assign done = enable && pre_wrap && (step_cnt == STEP_LAST);

    // R4: each wait starts from a cleared count
    p_fresh_start_r4: assert property (@(posedge clk) disable iff (rst)
        $rose(enable) |-> (pre_cnt == '0 && step_cnt == '0));

    // R4: the step counter only moves on a prescaler wrap
    p_step_on_wrap_r4: assert property (@(posedge clk) disable iff (rst)
        (enable && $past(enable) && step_cnt != $past(step_cnt)) |-> $past(pre_wrap));

endmodule

// File: rtl/vector_fetch.sv
module vector_fetch
    import bootseq_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        active,
    input  logic [7:0]  bus_din,
    output logic [15:0] bus_addr,
    output logic        bus_rd,
    output logic        last_step,
    output logic [15:0] vec_pc
);
    logic [STEP_W-1:0] step;
    logic [7:0]        lo_byte;

    always_ff @(posedge clk) begin
        if (rst || !active) begin
            step <= '0;
        end else if (step != STEP_W'(FETCH_CYCLES - 1)) begin
            step <= step + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            lo_byte <= 8'h00;
            vec_pc  <= 16'h0000;
        end else if (active && step == RD_LO_STEP) begin
            lo_byte <= bus_din;
        end else if (active && step == RD_HI_STEP) begin
            vec_pc  <= {bus_din, lo_byte};
        end
    end

    assign bus_addr  = active ? fetch_addr(step) : 16'h0000;
    assign bus_rd    = active && (step == RD_LO_STEP || step == RD_HI_STEP);
    assign last_step = active && (step == STEP_W'(FETCH_CYCLES - 1));

    // R5: the high byte read is always preceded by the low byte read
    p_lo_before_hi_r5: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && bus_addr == VEC_HI_ADDR) |-> $past(bus_rd && bus_addr == VEC_LO_ADDR));

    // R5: a read strobe never carries an address outside the vector pair
    p_rd_addr_r5: assert property (@(posedge clk) disable iff (rst)
        bus_rd |-> (bus_addr[15:1] == 15'h7FFF));

endmodule

// File: rtl/boot_sequencer.sv
module boot_sequencer
    import bootseq_pkg::*;
#(
    parameter int unsigned MIN_LOW    = 8,
    parameter int unsigned PRESCALE   = 1024,
    parameter int unsigned STAB_STEPS = 256
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        ext_rst_n,
    input  logic        wdt_rst_req,
    input  logic [7:0]  bus_din,
    output logic        core_rst,
    output logic [3:0]  init_ctl,
    output logic [15:0] bus_addr,
    output logic        bus_rd,
    output logic [15:0] pc_value,
    output logic        pc_load,
    output logic        run_en
);
    seq_state_e state, state_nx;
    logic       ext_active, take, stab_done, fetch_last, pc_load_q;
    init_ctl_t  init_s;

    pin_qualifier #(.MIN_LOW(MIN_LOW)) u_pin (
        .clk        (clk),
        .rst        (rst),
        .pin_n      (ext_rst_n),
        .ext_active (ext_active)
    );

    stab_timer #(.PRESCALE(PRESCALE), .STAB_STEPS(STAB_STEPS)) u_stab (
        .clk    (clk),
        .rst    (rst),
        .enable (state == SEQ_STAB),
        .done   (stab_done)
    );

    vector_fetch u_fetch (
        .clk       (clk),
        .rst       (rst),
        .active    (state == SEQ_FETCH),
        .bus_din   (bus_din),
        .bus_addr  (bus_addr),
        .bus_rd    (bus_rd),
        .last_step (fetch_last),
        .vec_pc    (pc_value)
    );

    assign take = ext_active || wdt_rst_req;

    always_comb begin
        state_nx = state;
        if (take) begin
            state_nx = SEQ_HOLD;
        end else begin
            case (state)
                SEQ_HOLD:  state_nx = SEQ_STAB;
                SEQ_STAB:  if (stab_done)  state_nx = SEQ_FETCH;
                SEQ_FETCH: if (fetch_last) state_nx = SEQ_RUN;
                default:   state_nx = SEQ_RUN;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= SEQ_HOLD;
            pc_load_q <= 1'b0;
        end else begin
            state     <= state_nx;
            pc_load_q <= (state == SEQ_FETCH) && (state_nx == SEQ_RUN);
        end
    end

    assign core_rst = (state == SEQ_HOLD);
    assign init_s   = init_all(core_rst);
    assign init_ctl = init_s;
    assign run_en   = (state == SEQ_RUN);
    assign pc_load  = pc_load_q;

    // R1: a watchdog request always lands in reset on the next cycle
    p_wdt_take_r1: assert property (@(posedge clk) disable iff (rst)
        wdt_rst_req |=> (core_rst && !run_en));

    // R7: running only ever starts straight out of the fetch
    p_run_entry_r7: assert property (@(posedge clk) disable iff (rst)
        $rose(run_en) |-> $past(state == SEQ_FETCH));

    // R6: the load pulse coincides with the first running cycle
    p_load_first_run_r6: assert property (@(posedge clk) disable iff (rst)
        pc_load |-> (run_en && $past(!run_en)));

    // R8: a reset during wait or fetch returns to the reset state
    p_abort_r8: assert property (@(posedge clk) disable iff (rst)
        ((state == SEQ_STAB || state == SEQ_FETCH) && take) |=> core_rst);

    // R9: no bus traffic while the core runs
    p_no_rd_run_r9: assert property (@(posedge clk) disable iff (rst)
        run_en |-> !bus_rd);

endmodule

// File: tb/boot_sequencer_bench.sv
module boot_sequencer_bench;
    localparam int unsigned PRE   = 4;
    localparam int unsigned STEPS = 3;
    localparam int W       = PRE * STEPS;
    localparam int LAT_SYN = 1 + W + 7;
    localparam int LAT_PIN = 4 + W + 7;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ext_rst_n = 1'b1;
    logic        wdt_rst_req = 1'b0;
    logic [7:0]  bus_din;
    logic        core_rst, bus_rd, pc_load, run_en;
    logic [3:0]  init_ctl;
    logic [15:0] bus_addr, pc_value;

    logic [7:0]  vlo = 8'h00, vhi = 8'h00;
    logic [15:0] exp_q[$];
    int          n_vec = 0, n_bad = 0, rd_cnt = 0;
    bit          saw_rst = 1'b0, done = 1'b0;

    always #5 clk = ~clk;

    assign bus_din = (bus_addr == 16'hFFFE) ? vlo :
                     (bus_addr == 16'hFFFF) ? vhi : 8'h00;

    boot_sequencer #(.MIN_LOW(8), .PRESCALE(PRE), .STAB_STEPS(STEPS)) u_boot_sequencer (
        .clk(clk), .rst(rst), .ext_rst_n(ext_rst_n), .wdt_rst_req(wdt_rst_req),
        .bus_din(bus_din), .core_rst(core_rst), .init_ctl(init_ctl),
        .bus_addr(bus_addr), .bus_rd(bus_rd), .pc_value(pc_value),
        .pc_load(pc_load), .run_en(run_en)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // monitor: scoreboard of vector reads, R5/R9
    always @(negedge clk) begin
        if (core_rst) saw_rst = 1'b1;
        if (!rst && bus_rd) begin
            rd_cnt++;
            if (exp_q.size() == 0) begin
                check(1'b0, "R5 unexpected read", {16'h0, bus_addr}, 32'h0);
            end else begin
                logic [15:0] e;
                e = exp_q.pop_front();
                check(bus_addr == e, "R5 read order", {16'h0, bus_addr}, {16'h0, e});
            end
            check(!run_en, "R9 read while running", {31'h0, run_en}, 32'h0);
        end
    end

    task automatic arm(input logic [7:0] lo, input logic [7:0] hi);
        vlo = lo; vhi = hi;
        exp_q.delete();
        exp_q.push_back(16'hFFFE);
        exp_q.push_back(16'hFFFF);
        rd_cnt = 0;
    endtask

    // waits for run_en; latency in edges since the caller's negedge (0 = unchecked)
    task automatic wait_run(input int exp_lat, input string req);
        int n;
        n = 0;
        while (!run_en && n < 200) begin
            @(negedge clk);
            n++;
        end
        if (exp_lat != 0) check(n == exp_lat, req, n, exp_lat);
        check(pc_load == 1'b1, "R6 pc_load on first run cycle", {31'h0, pc_load}, 32'h1);
        check(pc_value == {vhi, vlo}, "R6 pc value", {16'h0, pc_value}, {16'h0, vhi, vlo});
        check(rd_cnt == 2 && exp_q.size() == 0, "R5 two reads per sequence", rd_cnt, 2);
        check(init_ctl == 4'h0, "R3 strobes off while running", {28'h0, init_ctl}, 32'h0);
        @(negedge clk);
        check(pc_load == 1'b0, "R6 pc_load single cycle", {31'h0, pc_load}, 32'h0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R10 / R3: reset state
        check(core_rst && !run_en && !bus_rd && !pc_load, "R10 reset state",
              {28'h0, core_rst, run_en, bus_rd, pc_load}, 32'h8);
        check(init_ctl == 4'hF, "R3 strobes in reset", {28'h0, init_ctl}, 32'hF);

        // R4 / R7: power-on release
        arm(8'h5A, 8'hA5);
        rst = 1'b0;
        wait_run(LAT_SYN, "R4 latency after rst release");

        // R2: 7-sample glitch ignored
        saw_rst = 1'b0;
        ext_rst_n = 1'b0;
        repeat (7) @(negedge clk);
        ext_rst_n = 1'b1;
        repeat (6) @(negedge clk);
        check(!saw_rst && run_en, "R2 short pulse ignored", {30'h0, saw_rst, run_en}, 32'h1);

        // R2: long pulse taken after 11 edges
        begin
            int n;
            n = 0;
            ext_rst_n = 1'b0;
            while (!core_rst && n < 50) begin
                @(negedge clk);
                n++;
            end
            check(n == 11, "R2 pin take latency", n, 11);
            check(!run_en && init_ctl == 4'hF, "R3 strobes on pin reset", {27'h0, run_en, init_ctl}, 32'hF);
        end
        repeat (5) @(negedge clk);
        arm(8'h81, 8'h3C);
        ext_rst_n = 1'b1;
        wait_run(LAT_PIN, "R7 latency after pin release");

        // R2: exactly 8 samples is taken
        saw_rst = 1'b0;
        arm(8'h10, 8'h20);
        ext_rst_n = 1'b0;
        repeat (8) @(negedge clk);
        ext_rst_n = 1'b1;
        repeat (4) @(negedge clk);
        check(saw_rst, "R2 eight-sample pulse taken", {31'h0, saw_rst}, 32'h1);
        wait_run(0, "R2");

        // R1: watchdog request
        wdt_rst_req = 1'b1;
        @(negedge clk);
        check(core_rst && !run_en, "R1 watchdog take", {30'h0, core_rst, run_en}, 32'h2);
        arm(8'h01, 8'h7E);
        @(negedge clk);
        wdt_rst_req = 1'b0;
        wait_run(LAT_SYN, "R1 latency after watchdog");

        // R8: abort during stabilization wait
        wdt_rst_req = 1'b1;
        @(negedge clk);
        wdt_rst_req = 1'b0;
        arm(8'hC3, 8'h96);
        repeat (6) @(negedge clk);
        wdt_rst_req = 1'b1;
        @(negedge clk);
        check(core_rst && rd_cnt == 0, "R8 abort in wait", {31'h0, core_rst}, 32'h1);
        wdt_rst_req = 1'b0;
        wait_run(LAT_SYN, "R8 full wait repeated");

        // R8: abort between the two vector reads
        wdt_rst_req = 1'b1;
        @(negedge clk);
        wdt_rst_req = 1'b0;
        arm(8'hEE, 8'h11);
        while (!bus_rd) @(negedge clk);
        #1;
        wdt_rst_req = 1'b1;
        @(negedge clk);
        check(core_rst && !bus_rd, "R8 abort in fetch", {30'h0, core_rst, bus_rd}, 32'h2);
        check(rd_cnt == 1, "R8 high byte not read", rd_cnt, 1);
        arm(8'h44, 8'h55);
        wdt_rst_req = 1'b0;
        wait_run(LAT_SYN, "R8 refetch after abort");

        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        #2_000_000;
        if (!done) begin
            done = 1'b1;
            n_vec++;
            n_bad++;
            $display("FAIL watchdog expired actual=hung expected=done");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

endmodule